// File: doc/BRIEF.md
# Remote DMA Ready Status Tracker

This block holds the host-visible status byte that says when the host may safely touch the device. It keeps a remote transfer byte counter, 16 bits by default. The host loads it one byte lane at a time through byte-wide register writes. Each data-port access counts it down. When it reaches zero, a transfer-complete flag is raised.

Two more ready indications share the same byte. A read-data-ready flag drops when a remote-read command is issued. It comes back once the prefetch path reports that the first word is in place. A general device-ready flag is low whenever any of the busy sources is active: reset, power saving, configuration load or loopback-mode switching. The data store and the FIFO behind the data port are not part of the block. A single fetch-done pulse stands in for them.

All status flags and the counter are registered. Each one changes at the clock edge that samples its cause, so it is visible in the cycle after the input event.

Top module: `rdma_ready_status`

## Requirements
- R1: Status bit 4 (device ready) is 1 in the cycle after a clock edge at which no bit of `busy_i` is set, and 0 in the cycle after an edge at which any bit is set. The four `busy_i` bits are reset, power save, configuration load and mode switch, from bit 0 to bit 3.
- R2: Status bit 5 (read data ready) goes to 0 after an edge that samples `rd_cmd_i`, and goes to 1 after an edge that samples `fetch_done_i` without `rd_cmd_i`. When both are sampled together, the command wins and the bit goes to 0.
- R3: Once status bit 5 is 1, it stays 1 through any number of data-port accesses until the next read command.
- R4: `cnt_wr_i` bit 0 loads `wdata_i` into counter bits 7:0, and bit 1 loads it into bits 15:8. Both bits set in one cycle load both lanes. In a cycle with a write, a data-port access does not decrement the counter.
- R5: Status bit 6 (transfer complete) is 0 after any edge that samples a count-register write to either lane, even when the written count is zero.
- R6: Each data-port access with no count write decrements the counter by STEP (default 1). The counter saturates at zero and never wraps.
- R7: Status bit 6 becomes 1 when a data-port access leaves the counter at zero. A further access at zero keeps it at 1.
- R8: Status bits 0 to 3 and bit 7 always read 0.
- R9: While `rst_ni` is low, the counter reads 0 and the status byte reads 0x60: bit 4 is 0, and bits 5 and 6 are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_wr_i | input | 2 | Per-lane count-register write strobes (bit 0 low byte, bit 1 high byte) |
| wdata_i | input | 8 | Register write data |
| dp_access_i | input | 1 | Data-port access strobe |
| rd_cmd_i | input | 1 | Remote-read command issued |
| fetch_done_i | input | 1 | First read word available from the prefetch path |
| busy_i | input | 4 | Busy sources: reset, power save, configuration load, mode switch |
| status_o | output | 8 | Device status byte |
| count_o | output | 16 | Remaining remote byte count |

## Verification
The bench targets the following corner cases:

- **Access at zero.** A data-port access at a count of zero must not wrap the counter to all ones, and it must keep the complete flag set.
- **Write of zero.** Writing a zero count must still clear the complete flag. A design that recomputed the flag from the count would miss this.
- **Same-cycle collisions.** It checks a write against an access, where the access must not also decrement. It also checks a read command against a fetch-done pulse, where the command must win and leave read-ready low.
- **Step of two.** A second instance with a step of two starts from an odd count. A subtract-and-compare-equal design would underflow there instead of saturating.

Each busy source is raised alone, so a design that dropped one of them from the device-ready term would show it.

// File: rtl/rdma_status_pkg.sv
package rdma_status_pkg;
  localparam int unsigned STAT_W       = 8;
  localparam int unsigned BIT_DEV_RDY  = 4;
  localparam int unsigned BIT_RD_RDY   = 5;
  localparam int unsigned BIT_XFER_DON = 6;
  localparam int unsigned BUSY_N       = 4;

  typedef enum logic [1:0] {
    BUSY_RESET  = 2'd0,
    BUSY_PSAVE  = 2'd1,
    BUSY_CFGLD  = 2'd2,
    BUSY_MODESW = 2'd3
  } busy_src_e;
endpackage

// File: rtl/rdma_byte_counter.sv
module rdma_byte_counter #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned STEP   = 1,
  localparam int unsigned NLANE = CNT_W / BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NLANE-1:0]  wr_be_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              dec_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              done_o
);
  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

  logic [CNT_W-1:0] cnt_q, cnt_d, loaded, dec_val;
  logic             done_q, done_d;
  logic             any_wr;

  for (genvar b = 0; b < NLANE; b++) begin : g_lane
    assign loaded[b*BYTE_W +: BYTE_W] = wr_be_i[b] ? wdata_i : cnt_q[b*BYTE_W +: BYTE_W];
  end

  assign any_wr  = |wr_be_i;
  // saturating subtract
  assign dec_val = (cnt_q > STEP_V) ? (cnt_q - STEP_V) : '0;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (any_wr) begin
      cnt_d  = loaded;
      done_d = 1'b0;
    end else if (dec_i) begin
      cnt_d  = dec_val;
      done_d = (dec_val == '0) ? 1'b1 : done_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign count_o = cnt_q;
  assign done_o  = done_q;
endmodule

// File: rtl/rd_ready_tracker.sv
module rd_ready_tracker (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_cmd_i,
  input  logic fetch_done_i,
  output logic rd_rdy_o
);
  logic rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           rdy_q <= 1'b1;
    else if (rd_cmd_i)     rdy_q <= 1'b0;  // new command restarts prefetch
    else if (fetch_done_i) rdy_q <= 1'b1;
  end

  assign rd_rdy_o = rdy_q;
endmodule

// File: rtl/dev_ready_gate.sv
module dev_ready_gate #(
  parameter int unsigned NSRC = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] busy_i,
  output logic            dev_rdy_o
);
  logic rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_q <= 1'b0;
    else         rdy_q <= ~(|busy_i);
  end

  assign dev_rdy_o = rdy_q;
endmodule

// File: rtl/rdma_ready_status.sv
module rdma_ready_status
  import rdma_status_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned STEP   = 1,
  localparam int unsigned NLANE = CNT_W / BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NLANE-1:0]  cnt_wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              dp_access_i,
  input  logic              rd_cmd_i,
  input  logic              fetch_done_i,
  input  logic [BUSY_N-1:0] busy_i,
  output logic [STAT_W-1:0] status_o,
  output logic [CNT_W-1:0]  count_o
);
  logic xfer_done, rd_rdy, dev_rdy;

  rdma_byte_counter #(.CNT_W(CNT_W), .BYTE_W(BYTE_W), .STEP(STEP)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_be_i (cnt_wr_i),
    .wdata_i (wdata_i),
    .dec_i   (dp_access_i),
    .count_o (count_o),
    .done_o  (xfer_done)
  );

  rd_ready_tracker u_rd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_cmd_i     (rd_cmd_i),
    .fetch_done_i (fetch_done_i),
    .rd_rdy_o     (rd_rdy)
  );

  dev_ready_gate #(.NSRC(BUSY_N)) u_dev (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busy_i    (busy_i),
    .dev_rdy_o (dev_rdy)
  );

  always_comb begin
    status_o               = '0;
    status_o[BIT_DEV_RDY]  = dev_rdy;
    status_o[BIT_RD_RDY]   = rd_rdy;
    status_o[BIT_XFER_DON] = xfer_done;
  end
endmodule

// File: rtl/rdma_ready_status_chk.sv
module rdma_ready_status_chk
  import rdma_status_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned STEP   = 1,
  localparam int unsigned NLANE = CNT_W / BYTE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NLANE-1:0]  cnt_wr_i,
  input logic              dp_access_i,
  input logic              rd_cmd_i,
  input logic              fetch_done_i,
  input logic [BUSY_N-1:0] busy_i,
  input logic [STAT_W-1:0] status_o,
  input logic [CNT_W-1:0]  count_o
);
  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[3:0] == 4'h0) && !status_o[7]) else $error("rsvd"); // R8

  AST_BUSY_DROPS_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|busy_i) |=> !status_o[BIT_DEV_RDY]) else $error("dev rdy"); // R1

  AST_RDCMD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cmd_i |=> !status_o[BIT_RD_RDY]) else $error("rd clr"); // R2

  AST_FETCH_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_done_i && !rd_cmd_i) |=> status_o[BIT_RD_RDY]) else $error("rd set"); // R2

  AST_RDRDY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[BIT_RD_RDY] && !rd_cmd_i) |=> status_o[BIT_RD_RDY]) else $error("rd hold"); // R3

  AST_WR_CLEARS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cnt_wr_i) |=> !status_o[BIT_XFER_DON]) else $error("done clr"); // R5

  AST_DEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp_access_i && cnt_wr_i == '0 && count_o >= STEP_V) |=>
      (count_o == $past(count_o) - STEP_V)) else $error("dec"); // R6

  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp_access_i && cnt_wr_i == '0 && count_o <= STEP_V) |=>
      (count_o == '0)) else $error("wrap"); // R6

  AST_ZERO_SETS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp_access_i && cnt_wr_i == '0 && count_o <= STEP_V) |=>
      status_o[BIT_XFER_DON]) else $error("done set"); // R7
endmodule

bind rdma_ready_status rdma_ready_status_chk #(
  .CNT_W(CNT_W), .BYTE_W(BYTE_W), .STEP(STEP)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cnt_wr_i     (cnt_wr_i),
  .dp_access_i  (dp_access_i),
  .rd_cmd_i     (rd_cmd_i),
  .fetch_done_i (fetch_done_i),
  .busy_i       (busy_i),
  .status_o     (status_o),
  .count_o      (count_o)
);

// File: tb/rdma_ready_status_test.sv
module rdma_ready_status_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cnt_wr = '0;
  logic [7:0]  wdata = '0;
  logic        dp = 1'b0, cmd = 1'b0, fetch = 1'b0;
  logic [3:0]  busy = '0;
  logic [7:0]  st, st2;
  logic [15:0] cnt, cnt2;
  int checks = 0, fails = 0, cycles = 0;

  always #5 clk = ~clk;

  rdma_ready_status uut (
    .clk_i(clk), .rst_ni(rst_n), .cnt_wr_i(cnt_wr), .wdata_i(wdata),
    .dp_access_i(dp), .rd_cmd_i(cmd), .fetch_done_i(fetch), .busy_i(busy),
    .status_o(st), .count_o(cnt));

  rdma_ready_status #(.STEP(2)) uut_w2 (
    .clk_i(clk), .rst_ni(rst_n), .cnt_wr_i(cnt_wr), .wdata_i(wdata),
    .dp_access_i(dp), .rd_cmd_i(cmd), .fetch_done_i(fetch), .busy_i(busy),
    .status_o(st2), .count_o(cnt2));

  // {cnt_wr, wdata, dp, cmd, fetch, busy, exp_status, exp_count}
  localparam int NV = 29;
  localparam logic [40:0] VEC [NV] = '{
    {2'b00, 8'h00, 1'b0, 1'b0, 1'b0, 4'h0, 8'h70, 16'h0000},
    {2'b01, 8'h03, 1'b0, 1'b0, 1'b0, 4'h0, 8'h30, 16'h0003},
    {2'b10, 8'h01, 1'b0, 1'b0, 1'b0, 4'h0, 8'h30, 16'h0103},
    {2'b00, 8'h00, 1'b1, 1'b0, 1'b0, 4'h0, 8'h30, 16'h0102},
    {2'b11, 8'h00, 1'b0, 1'b0, 1'b0, 4'h0, 8'h30, 16'h0000},
    {2'b01, 8'h02, 1'b0, 1'b0, 1'b0, 4'h0, 8'h30, 16'h0002},
    {2'b01, 8'h05, 1'b1, 1'b0, 1'b0, 4'h0, 8'h30, 16'h0005},
    {2'b00, 8'h00, 1'b1, 1'b0, 1'b0, 4'h0, 8'h30, 16'h0004},
    {2'b00, 8'h00, 1'b1, 1'b0, 1'b0, 4'h0, 8'h30, 16'h0003},
    {2'b00, 8'h00, 1'b1, 1'b0, 1'b0, 4'h0, 8'h30, 16'h0002},
    {2'b00, 8'h00, 1'b1, 1'b0, 1'b0, 4'h0, 8'h30, 16'h0001},
    {2'b00, 8'h00, 1'b1, 1'b0, 1'b0, 4'h0, 8'h70, 16'h0000},
    {2'b00, 8'h00, 1'b1, 1'b0, 1'b0, 4'h0, 8'h70, 16'h0000},
    {2'b00, 8'h00, 1'b0, 1'b1, 1'b0, 4'h0, 8'h50, 16'h0000},
    {2'b00, 8'h00, 1'b0, 1'b0, 1'b0, 4'h0, 8'h50, 16'h0000},
    {2'b00, 8'h00, 1'b0, 1'b0, 1'b1, 4'h0, 8'h70, 16'h0000},
    {2'b00, 8'h00, 1'b1, 1'b0, 1'b0, 4'h0, 8'h70, 16'h0000},
    {2'b00, 8'h00, 1'b1, 1'b0, 1'b0, 4'h0, 8'h70, 16'h0000},
    {2'b00, 8'h00, 1'b0, 1'b1, 1'b1, 4'h0, 8'h50, 16'h0000},
    {2'b00, 8'h00, 1'b0, 1'b0, 1'b1, 4'h0, 8'h70, 16'h0000},
    {2'b00, 8'h00, 1'b0, 1'b0, 1'b0, 4'h1, 8'h60, 16'h0000},
    {2'b00, 8'h00, 1'b0, 1'b0, 1'b0, 4'h2, 8'h60, 16'h0000},
    {2'b00, 8'h00, 1'b1, 1'b0, 1'b0, 4'h4, 8'h60, 16'h0000},
    {2'b00, 8'h00, 1'b0, 1'b0, 1'b0, 4'h8, 8'h60, 16'h0000},
    {2'b00, 8'h00, 1'b0, 1'b0, 1'b0, 4'h0, 8'h70, 16'h0000},
    {2'b10, 8'h00, 1'b0, 1'b0, 1'b0, 4'h0, 8'h30, 16'h0000},
    {2'b00, 8'h00, 1'b1, 1'b0, 1'b0, 4'h0, 8'h70, 16'h0000},
    {2'b11, 8'hff, 1'b0, 1'b0, 1'b0, 4'h0, 8'h30, 16'hffff},
    {2'b00, 8'h00, 1'b1, 1'b0, 1'b0, 4'h0, 8'h30, 16'hfffe}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic drive(input logic [1:0] w, input logic [7:0] d, input logic a);
    cnt_wr = w; wdata = d; dp = a;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=<5000", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R9 status in reset", 32'(st), 32'h60);
    chk("R9 count in reset", 32'(cnt), 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {cnt_wr, wdata, dp, cmd, fetch, busy} = VEC[i][40:24];
      @(negedge clk);
      chk($sformatf("R1 dev_rdy v%0d", i), 32'(st[4]), 32'(VEC[i][16+4]));
      chk($sformatf("R2/R3 rd_rdy v%0d", i), 32'(st[5]), 32'(VEC[i][16+5]));
      chk($sformatf("R5/R7 done v%0d", i), 32'(st[6]), 32'(VEC[i][16+6]));
      chk($sformatf("R8 rsvd v%0d", i), 32'({st[7], st[3:0]}), 32'h0);
      chk($sformatf("R4/R6 count v%0d", i), 32'(cnt), 32'(VEC[i][15:0]));
    end
    {cnt_wr, wdata, dp, cmd, fetch, busy} = '0;

    // step-of-two instance: saturation from odd count
    drive(2'b11, 8'h00, 1'b0); @(negedge clk);
    drive(2'b01, 8'h03, 1'b0); @(negedge clk);
    chk("R4 w2 load", 32'(cnt2), 32'h3);
    drive(2'b00, 8'h00, 1'b1); @(negedge clk);
    chk("R6 w2 step", 32'(cnt2), 32'h1);
    chk("R6 w1 step", 32'(cnt), 32'h2);
    @(negedge clk);
    chk("R6 w2 saturate", 32'(cnt2), 32'h0);
    chk("R7 w2 done", 32'(st2[6]), 32'h1);
    chk("R5 w1 not done", 32'(st[6]), 32'h0);
    @(negedge clk);
    chk("R6 w1 zero", 32'(cnt), 32'h0);
    chk("R7 w1 done", 32'(st[6]), 32'h1);
    chk("R6 w2 no wrap", 32'(cnt2), 32'h0);
    drive(2'b00, 8'h00, 1'b0);

    // asynchronous reset mid-run
    drive(2'b01, 8'h44, 1'b0); @(negedge clk);
    drive(2'b00, 8'h00, 1'b0);
    cmd = 1'b1; @(negedge clk); cmd = 1'b0;
    #2 rst_n = 1'b0; #1;
    chk("R9 async count", 32'(cnt), 32'h0);
    chk("R9 async status", 32'(st), 32'h60);
    @(negedge clk);
    chk("R1 held in reset", 32'(st[4]), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", 32'(st[4]), 32'h1);
    finish_run();
  end
endmodule